// File: doc/BRIEF.md
# Operand Effective Address Generator

This block forms the 16-bit effective address of an operand for a small 16-bit processor. The decode stage gives it an addressing-mode code, a base selector, an index selector and the 16-bit constant from the instruction. The register file supplies the current contents of the six candidate registers: BX, BP, SI, DI, SP and DX. The block selects the register terms that the mode needs and adds them to the constant when the mode calls for it. It also checks the register choice against the machine's addressing rules.

Each address request is marked by a one-cycle start strobe. One clock later the registered outputs carry either the new address with a valid strobe, or an illegal flag. When the flag is set, the address output keeps its previous value. Every sum wraps modulo 2^16 and no carry is reported. For an I/O port operand, the address is the value of DX, and DX is the only register allowed for that purpose.

Top module: `operand_ea_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears `ea` to 0 and drives `ea_valid` and `ea_illegal` low.
- R2: Mode code 0 (direct) is always legal. Its address is `disp`.
- R3: Mode code 1 (register indirect) takes the register named by `base_sel` as the address. It is legal only for selector codes 0 (BX), 1 (BP), 2 (SI) and 3 (DI).
- R4: Mode code 2 (register plus constant) gives the `base_sel` register plus `disp`. It takes the same four registers as R3. Selector 4 (SP) is flagged illegal.
- R5: Mode code 3 (base plus index) gives the `base_sel` register plus the `index_sel` register. It is legal only when `base_sel` is BX (0) or BP (1) and `index_sel` is SI (2) or DI (3).
- R6: Mode code 4 (base plus index plus constant) adds `disp` to the R5 sum, under the same register restrictions as R5.
- R7: Mode code 5 (I/O port) gives the value of DX. It is legal only when `base_sel` is 5 (DX).
- R8: All sums are taken modulo 2^16; a carry out of bit 15 is discarded and is not reported.
- R9: After a start with an illegal combination, `ea_illegal` is high, `ea_valid` is low and `ea` keeps the value it had before that start.
- R10: Results appear on the first clock edge after the start strobe. After an edge without start, `ea_valid` and `ea_illegal` are both low and `ea` is unchanged.
- R11: Mode codes 6 and 7 are illegal, and so are selector codes 6 and 7 wherever a register is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request strobe |
| mode | input | 3 | Addressing-mode code |
| base_sel | input | 3 | Base / single register selector |
| index_sel | input | 3 | Index register selector |
| disp | input | 16 | Constant carried in the instruction |
| reg_bx | input | 16 | Current BX value |
| reg_bp | input | 16 | Current BP value |
| reg_si | input | 16 | Current SI value |
| reg_di | input | 16 | Current DI value |
| reg_sp | input | 16 | Current SP value |
| reg_dx | input | 16 | Current DX value |
| ea | output | 16 | Registered effective address |
| ea_valid | output | 1 | Address is valid for the last request |
| ea_illegal | output | 1 | Last request used an illegal combination |

## Verification
All three outputs are due exactly one rising edge after the cycle in which `start` is high. The bench drives each request on a falling edge and removes `start` on the next falling edge. It samples `ea`, `ea_valid` and `ea_illegal` at that second falling edge, which is half a period after the capturing edge. The cycles in between are sampled the same way, to show that valid and illegal fall back low while the address holds. Expected values come from bench functions that apply the mode and register rules to the register values driven for that request.

// File: rtl/ea_pkg.sv
// Package: shared encodings for the effective address generator.
// Assumes a 3-bit mode code and 3-bit register selectors, as decoded upstream.
package ea_pkg;

    localparam int EA_W    = 16;
    localparam int MODE_W  = 3;
    localparam int SEL_W   = 3;
    localparam int N_PICK  = 2;

    typedef enum logic [MODE_W-1:0] {
        AM_DIRECT    = 3'd0,
        AM_REG       = 3'd1,
        AM_REG_DISP  = 3'd2,
        AM_PAIR      = 3'd3,
        AM_PAIR_DISP = 3'd4,
        AM_PORT      = 3'd5,
        AM_RSV6      = 3'd6,
        AM_RSV7      = 3'd7
    } am_mode_e;

    typedef enum logic [SEL_W-1:0] {
        RS_BX    = 3'd0,
        RS_BP    = 3'd1,
        RS_SI    = 3'd2,
        RS_DI    = 3'd3,
        RS_SP    = 3'd4,
        RS_DX    = 3'd5,
        RS_NONE6 = 3'd6,
        RS_NONE7 = 3'd7
    } rsel_e;

    // Terms that the adder must include for a given mode.
    typedef struct packed {
        logic use_base;
        logic use_index;
        logic use_disp;
    } term_set_t;

endpackage

// File: rtl/ea_reg_pick.sv
// Module: ea_reg_pick
// Selects one register value by selector code. Selectors that name no
// register return zero; legality is judged elsewhere.
module ea_reg_pick
    import ea_pkg::*;
#(
    parameter int W = EA_W
) (
    input  rsel_e          sel,
    input  logic [W-1:0]   r_bx,
    input  logic [W-1:0]   r_bp,
    input  logic [W-1:0]   r_si,
    input  logic [W-1:0]   r_di,
    input  logic [W-1:0]   r_sp,
    input  logic [W-1:0]   r_dx,
    output logic [W-1:0]   value
);

    // Register selection multiplexer.
    always_comb begin
        unique case (sel)
            RS_BX:   value = r_bx;
            RS_BP:   value = r_bp;
            RS_SI:   value = r_si;
            RS_DI:   value = r_di;
            RS_SP:   value = r_sp;
            RS_DX:   value = r_dx;
            default: value = '0;
        endcase
    end

endmodule

// File: rtl/ea_rule_check.sv
// Module: ea_rule_check
// Decides whether a mode/selector combination is permitted and which
// terms the address sum uses. Assumes the selector encodings of ea_pkg.
module ea_rule_check
    import ea_pkg::*;
(
    input  am_mode_e   mode,
    input  rsel_e      base_sel,
    input  rsel_e      index_sel,
    output logic       legal,
    output term_set_t  terms
);

    logic ptr_ok;
    logic base_ok;
    logic index_ok;
    logic port_ok;

    // Classify the selectors against the addressing rules.
    always_comb begin
        ptr_ok   = (base_sel == RS_BX) || (base_sel == RS_BP) ||
                   (base_sel == RS_SI) || (base_sel == RS_DI);
        base_ok  = (base_sel == RS_BX) || (base_sel == RS_BP);
        index_ok = (index_sel == RS_SI) || (index_sel == RS_DI);
        port_ok  = (base_sel == RS_DX);
    end

    // Per-mode legality and choice of summed terms.
    always_comb begin
        legal = 1'b0;
        terms = '0;
        unique case (mode)
            AM_DIRECT: begin
                legal = 1'b1;
                terms = '{use_base: 1'b0, use_index: 1'b0, use_disp: 1'b1};
            end
            AM_REG: begin
                legal = ptr_ok;
                terms = '{use_base: 1'b1, use_index: 1'b0, use_disp: 1'b0};
            end
            AM_REG_DISP: begin
                legal = ptr_ok;
                terms = '{use_base: 1'b1, use_index: 1'b0, use_disp: 1'b1};
            end
            AM_PAIR: begin
                legal = base_ok && index_ok;
                terms = '{use_base: 1'b1, use_index: 1'b1, use_disp: 1'b0};
            end
            AM_PAIR_DISP: begin
                legal = base_ok && index_ok;
                terms = '{use_base: 1'b1, use_index: 1'b1, use_disp: 1'b1};
            end
            AM_PORT: begin
                legal = port_ok;
                terms = '{use_base: 1'b1, use_index: 1'b0, use_disp: 1'b0};
            end
            default: begin
                legal = 1'b0;
                terms = '0;
            end
        endcase
    end

endmodule

// File: rtl/ea_sum_unit.sv
// Module: ea_sum_unit
// Three-term modular adder. Unused terms are gated to zero; the carry
// out of the top bit is dropped by the width of the result.
module ea_sum_unit
    import ea_pkg::*;
#(
    parameter int W = EA_W
) (
    input  term_set_t     terms,
    input  logic [W-1:0]  base_val,
    input  logic [W-1:0]  index_val,
    input  logic [W-1:0]  disp,
    output logic [W-1:0]  sum
);

    logic [W-1:0] t_base;
    logic [W-1:0] t_index;
    logic [W-1:0] t_disp;

    // Gate the terms and add them with wrap-around.
    always_comb begin
        t_base  = terms.use_base  ? base_val  : '0;
        t_index = terms.use_index ? index_val : '0;
        t_disp  = terms.use_disp  ? disp      : '0;
        sum     = t_base + t_index + t_disp;
    end

endmodule

// File: rtl/operand_ea_unit.sv
// Module: operand_ea_unit
// Top level: forms the effective address of an operand and flags illegal
// register combinations. Assumes start is a single-cycle strobe and the
// register values are stable in the start cycle. Results are registered.
module operand_ea_unit
    import ea_pkg::*;
#(
    parameter int ADDR_W = EA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [MODE_W-1:0]  mode,
    input  logic [SEL_W-1:0]   base_sel,
    input  logic [SEL_W-1:0]   index_sel,
    input  logic [ADDR_W-1:0]  disp,
    input  logic [ADDR_W-1:0]  reg_bx,
    input  logic [ADDR_W-1:0]  reg_bp,
    input  logic [ADDR_W-1:0]  reg_si,
    input  logic [ADDR_W-1:0]  reg_di,
    input  logic [ADDR_W-1:0]  reg_sp,
    input  logic [ADDR_W-1:0]  reg_dx,
    output logic [ADDR_W-1:0]  ea,
    output logic               ea_valid,
    output logic               ea_illegal
);

    rsel_e               pick_sel [N_PICK];
    logic [ADDR_W-1:0]   pick_val [N_PICK];
    logic                legal;
    term_set_t           terms;
    logic [ADDR_W-1:0]   ea_next;

    assign pick_sel[0] = rsel_e'(base_sel);
    assign pick_sel[1] = rsel_e'(index_sel);

    // One register picker for the base term and one for the index term.
    generate
        for (genvar g = 0; g < N_PICK; g++) begin : g_pick
            ea_reg_pick #(.W(ADDR_W)) pick_i (
                .sel   (pick_sel[g]),
                .r_bx  (reg_bx),
                .r_bp  (reg_bp),
                .r_si  (reg_si),
                .r_di  (reg_di),
                .r_sp  (reg_sp),
                .r_dx  (reg_dx),
                .value (pick_val[g])
            );
        end
    endgenerate

    ea_rule_check rule_i (
        .mode      (am_mode_e'(mode)),
        .base_sel  (pick_sel[0]),
        .index_sel (pick_sel[1]),
        .legal     (legal),
        .terms     (terms)
    );

    ea_sum_unit #(.W(ADDR_W)) sum_i (
        .terms     (terms),
        .base_val  (pick_val[0]),
        .index_val (pick_val[1]),
        .disp      (disp),
        .sum       (ea_next)
    );

    // Result register: capture on start, hold the address otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea         <= '0;
            ea_valid   <= 1'b0;
            ea_illegal <= 1'b0;
        end else begin
            ea_valid   <= start && legal;
            ea_illegal <= start && !legal;
            if (start && legal) begin
                ea <= ea_next;
            end
        end
    end

endmodule

// File: rtl/operand_ea_unit_checker.sv
// Module: operand_ea_unit_checker
// Temporal checks on the ports of operand_ea_unit, attached by bind.
module operand_ea_unit_checker
    import ea_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic [MODE_W-1:0]   mode,
    input logic [SEL_W-1:0]    base_sel,
    input logic [SEL_W-1:0]    index_sel,
    input logic [EA_W-1:0]     disp,
    input logic [EA_W-1:0]     reg_dx,
    input logic [EA_W-1:0]     reg_sp,
    input logic [EA_W-1:0]     ea,
    input logic                ea_valid,
    input logic                ea_illegal
);

    // R10: an edge without start leaves both strobes low.
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (!ea_valid && !ea_illegal));

    // R10: the address only changes as the result of a start.
    a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(ea));

    // R9: valid and illegal never together; illegal keeps the address.
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ea_valid && ea_illegal));

    a_r9_hold_on_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        ea_illegal |-> $stable(ea));

    // R2: direct mode yields the constant.
    a_r2_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode == 3'd0) |=> (ea_valid && ea == $past(disp)));

    // R7: port mode through DX yields DX.
    a_r7_port_dx: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode == 3'd5 && base_sel == 3'd5) |=> (ea_valid && ea == $past(reg_dx)));

    // R4: stack pointer plus constant is refused.
    a_r4_sp_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode == 3'd2 && base_sel == 3'd4) |=> ea_illegal);

    // R11: reserved mode codes are refused.
    a_r11_rsv_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode[2] && mode[1]) |=> ea_illegal);

    // R5: a based form with a non-index second register is refused.
    a_r5_bad_index: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode == 3'd3 && index_sel[2:1] != 2'b01) |=> ea_illegal);

    logic unused_ok;
    assign unused_ok = ^{reg_sp, index_sel[0]};

endmodule

bind operand_ea_unit operand_ea_unit_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mode       (mode),
    .base_sel   (base_sel),
    .index_sel  (index_sel),
    .disp       (disp),
    .reg_dx     (reg_dx),
    .reg_sp     (reg_sp),
    .ea         (ea),
    .ea_valid   (ea_valid),
    .ea_illegal (ea_illegal)
);

// File: tb/operand_ea_unit_tb_top.sv
// Bench: directed corner cases plus seeded random requests, checked
// against bench functions built from the requirements.
module operand_ea_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [2:0]  mode;
    logic [2:0]  base_sel;
    logic [2:0]  index_sel;
    logic [15:0] disp;
    logic [15:0] reg_bx, reg_bp, reg_si, reg_di, reg_sp, reg_dx;
    logic [15:0] ea;
    logic        ea_valid;
    logic        ea_illegal;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_ea = 16'h0000;

    always #10 clk = ~clk;

    operand_ea_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .base_sel(base_sel), .index_sel(index_sel), .disp(disp),
        .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
        .reg_sp(reg_sp), .reg_dx(reg_dx),
        .ea(ea), .ea_valid(ea_valid), .ea_illegal(ea_illegal)
    );

    function automatic logic [15:0] rv(input logic [2:0] s);
        case (s)
            3'd0:    return reg_bx;
            3'd1:    return reg_bp;
            3'd2:    return reg_si;
            3'd3:    return reg_di;
            3'd4:    return reg_sp;
            3'd5:    return reg_dx;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic legal_f(input logic [2:0] m, input logic [2:0] b, input logic [2:0] i);
        case (m)
            3'd0:       return 1'b1;
            3'd1, 3'd2: return b < 3'd4;
            3'd3, 3'd4: return (b < 3'd2) && (i == 3'd2 || i == 3'd3);
            3'd5:       return b == 3'd5;
            default:    return 1'b0;
        endcase
    endfunction

    function automatic logic [15:0] ea_f(input logic [2:0] m, input logic [2:0] b,
                                         input logic [2:0] i, input logic [15:0] d);
        case (m)
            3'd0:    return d;
            3'd1:    return rv(b);
            3'd2:    return rv(b) + d;
            3'd3:    return rv(b) + rv(i);
            3'd4:    return rv(b) + rv(i) + d;
            3'd5:    return reg_dx;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string tag_f(input logic [2:0] m);
        case (m)
            3'd0:    return "R2";
            3'd1:    return "R3";
            3'd2:    return "R4";
            3'd3:    return "R5";
            3'd4:    return "R6";
            3'd5:    return "R7";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] a_ea, input logic a_v,
                         input logic a_il, input logic [15:0] e_ea, input logic e_v,
                         input logic e_il);
        checks++;
        if (a_ea !== e_ea || a_v !== e_v || a_il !== e_il) begin
            errors++;
            $display("FAIL %s actual ea=%h v=%b il=%b expected ea=%h v=%b il=%b",
                     req, a_ea, a_v, a_il, e_ea, e_v, e_il);
        end
    endtask

    // Drive one request, wait for the capturing edge, sample at the next falling edge.
    task automatic issue(input logic [2:0] m, input logic [2:0] b, input logic [2:0] i,
                         input logic [15:0] d, input string req);
        logic ok;
        @(negedge clk);
        mode = m; base_sel = b; index_sel = i; disp = d; start = 1'b1;
        ok = legal_f(m, b, i);
        if (ok) exp_ea = ea_f(m, b, i, d);
        @(negedge clk);
        start = 1'b0;
        check(req, ea, ea_valid, ea_illegal, exp_ea, ok, !ok);
    endtask

    task automatic set_regs(input logic [15:0] bx, input logic [15:0] bp, input logic [15:0] si,
                            input logic [15:0] di, input logic [15:0] sp, input logic [15:0] dx);
        reg_bx = bx; reg_bp = bp; reg_si = si; reg_di = di; reg_sp = sp; reg_dx = dx;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; mode = '0; base_sel = '0; index_sel = '0; disp = '0;
        set_regs(16'h1000, 16'h2000, 16'h0030, 16'h0004, 16'hFFFE, 16'h04E9);
        repeat (3) @(negedge clk);
        check("R1", ea, ea_valid, ea_illegal, 16'h0000, 1'b0, 1'b0);
        rst_n = 1'b1;

        issue(3'd0, 3'd0, 3'd0, 16'h3FC0, "R2");
        issue(3'd1, 3'd0, 3'd0, 16'h0000, "R3");
        issue(3'd1, 3'd3, 3'd0, 16'h0000, "R3");
        issue(3'd1, 3'd5, 3'd0, 16'h0000, "R3");
        issue(3'd2, 3'd2, 3'd0, 16'h0100, "R4");
        issue(3'd2, 3'd4, 3'd0, 16'h0002, "R4");
        issue(3'd3, 3'd1, 3'd3, 16'h0000, "R5");
        issue(3'd3, 3'd2, 3'd3, 16'h0000, "R5");
        issue(3'd3, 3'd0, 3'd1, 16'h0000, "R5");
        issue(3'd4, 3'd0, 3'd2, 16'h0008, "R6");
        issue(3'd4, 3'd1, 3'd4, 16'h0008, "R6");
        issue(3'd5, 3'd5, 3'd0, 16'h0000, "R7");
        issue(3'd5, 3'd0, 3'd0, 16'h0000, "R7");

        // R8: wrap past 16 bits without any carry indication.
        set_regs(16'hFFFF, 16'hFFF0, 16'h0002, 16'h8000, 16'hFFFE, 16'h04E9);
        issue(3'd4, 3'd0, 3'd2, 16'h0003, "R8");
        issue(3'd3, 3'd1, 3'd3, 16'h0000, "R8");
        issue(3'd2, 3'd3, 3'd0, 16'h8000, "R8");

        // R9: an illegal request keeps the last good address.
        issue(3'd0, 3'd0, 3'd0, 16'hABCD, "R9");
        issue(3'd3, 3'd4, 3'd5, 16'h0000, "R9");

        // R10: an idle edge drops both strobes and holds the address.
        @(negedge clk);
        check("R10", ea, ea_valid, ea_illegal, exp_ea, 1'b0, 1'b0);

        // R11: reserved mode and selector codes.
        issue(3'd6, 3'd0, 3'd2, 16'h0000, "R11");
        issue(3'd7, 3'd0, 3'd2, 16'h0000, "R11");
        issue(3'd1, 3'd6, 3'd0, 16'h0000, "R11");
        issue(3'd4, 3'd0, 3'd7, 16'h0000, "R11");

        // Seeded random requests, with occasional idle gaps.
        void'($urandom(32'h5EED_0042));
        for (int n = 0; n < 400; n++) begin
            logic [2:0] m;
            logic [2:0] b;
            logic [2:0] i;
            set_regs(16'($urandom), 16'($urandom), 16'($urandom),
                     16'($urandom), 16'($urandom), 16'($urandom));
            m = 3'($urandom_range(0, 7));
            b = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7)) : 3'($urandom_range(0, 3));
            i = ($urandom_range(0, 3) == 0) ? 3'($urandom_range(0, 7)) : 3'($urandom_range(2, 3));
            if (m == 3'd5 && $urandom_range(0, 1) == 1) b = 3'd5;
            issue(m, b, i, 16'($urandom), legal_f(m, b, i) ? tag_f(m) : "R9");
            if ($urandom_range(0, 4) == 0) begin
                @(negedge clk);
                check("R10", ea, ea_valid, ea_illegal, exp_ea, 1'b0, 1'b0);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule